// File: doc/BRIEF.md
# Audio Error Concealment Interpolator

This block sits after the error-correction stage of a digital audio decoder. It receives one 16-bit two's complement sample per `in_valid` strobe. Left and right samples alternate, and the first sample after reset is left. With each sample come the status bits of the two correction stages. From these the block forms a single "uncorrectable" flag for the sample. Every sample comes out again with its flag passed through. A flagged sample has its value replaced by a concealment value.

Each channel keeps its own history. A flagged sample between two unflagged samples of the same channel is replaced by the mean of those two neighbours. A flagged sample that is part of a run of two or more flagged samples is replaced by the last unflagged value of its channel. The block must see the next sample before it decides, so each channel's output runs one sample behind its input.

Top module: `conceal_interp`

## Requirements
- R1: A sample is flagged when `c2_fail` is 1, or when `c2_corrected` and `c1_flag` are both 1. `c1_flag` alone, or `c2_corrected` alone, does not flag the sample. `out_flag` carries the flag of the sample being output.
- R2: An unflagged sample is output with its value unchanged and with `out_flag` = 0.
- R3: A flagged sample whose same-channel predecessor and successor are both unflagged is output as (prev + next) >>> 1. The sum is formed at 17 bits and shifted arithmetically, so odd sums round toward minus infinity.
- R4: A flagged sample that has a flagged same-channel neighbour on either side is output as the last unflagged value of that channel.
- R5: If a channel has had no unflagged sample since reset, a flagged sample on that channel is output as 0.
- R6: Channel history is independent. `out_chan` is 0 for left and 1 for right, and the first accepted sample after reset is left.
- R7: The output for a channel's sample k is registered in the cycle in which that channel's sample k+1 is accepted. `out_valid` is a one-cycle pulse, and nothing is output for the first sample of each channel.
- R8: After reset, `out_valid`, `out_data` and `out_flag` are 0. All channel history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one sample per high cycle |
| in_data | input | 16 | Sample, two's complement |
| c1_flag | input | 1 | First-stage decoder error flag |
| c2_fail | input | 1 | Second-stage check failed |
| c2_corrected | input | 1 | Second-stage check passed after correcting |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Concealed sample |
| out_flag | output | 1 | Flag of the output sample |
| out_chan | output | 1 | Channel of the output sample |

## Verification
The hardest case to reach is a run that starts right after an isolated concealment on the other channel. Reaching it requires interleaving, where the left channel is in a hold run while the right channel interpolates. A single stream in the vector table drives both channels through these states at the same time. The same stream also covers a 16-bit extreme, a negative odd sum, and both single-bit flag combinations. Directed tests then reset in the middle of a stream, to check that a flagged first sample gives 0 rather than half its successor.

// File: rtl/conceal_pkg.sv
// Package: shared widths and the per-sample record used by the concealer.
package conceal_pkg;
    localparam int SAMPLE_W = 16;
    localparam int NUM_CH   = 2;
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t data;
        logic    bad;
    } tagged_t;
endpackage

// File: rtl/conceal_flag.sv
// Module: conceal_flag
// Forms the final per-sample error flag from the two decoder stage status bits.
// Assumes the status bits are valid in the same cycle as the sample.
module conceal_flag (
    input  logic c1_flag,
    input  logic c2_fail,
    input  logic c2_corrected,
    output logic bad
);
    // Flag on second-stage failure or on a correction made on top of a first-stage error.
    always_comb bad = c2_fail | (c2_corrected & c1_flag);
endmodule

// File: rtl/conceal_chan.sv
// Module: conceal_chan
// History for one channel. It holds one pending sample, whether the sample before
// that was flagged, and the last unflagged value. When a new sample arrives it
// emits the concealed value of the pending one.
// Assumes push is high for exactly the samples that belong to this channel.
module conceal_chan
    import conceal_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  tagged_t din,
    output logic    emit,
    output tagged_t dout
);
    tagged_t               pend;
    logic                  pend_vld;
    logic                  prev_bad;
    sample_t               last_good;
    logic                  has_good;
    logic signed [SAMPLE_W:0] sum;
    logic                  lone;

    // Decide the value of the pending sample from its neighbours.
    always_comb begin
        sum  = {last_good[SAMPLE_W-1], last_good} + {din.data[SAMPLE_W-1], din.data};
        lone = !prev_bad && !din.bad && has_good;
        emit = push && pend_vld;
        dout.bad = pend.bad;
        if (!pend.bad)
            dout.data = pend.data;
        else if (lone)
            dout.data = sum[SAMPLE_W:1];
        else
            dout.data = last_good;
    end

    // Shift the new sample in and update the channel history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            pend_vld  <= 1'b0;
            prev_bad  <= 1'b0;
            last_good <= '0;
            has_good  <= 1'b0;
        end else if (push) begin
            pend     <= din;
            pend_vld <= 1'b1;
            if (pend_vld) begin
                prev_bad <= pend.bad;
                if (!pend.bad) begin
                    last_good <= pend.data;
                    has_good  <= 1'b1;
                end
            end
        end
    end

    // R5
    no_good_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && pend.bad && !has_good) |-> (dout.data == '0));

    // R3
    interp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && pend.bad && lone) |->
        ((dout.data >= ((last_good < din.data) ? last_good : din.data)) &&
         (dout.data <= ((last_good < din.data) ? din.data : last_good))));

    // R4
    good_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(has_good));
endmodule

// File: rtl/conceal_interp.sv
// Module: conceal_interp (top)
// Splits the alternating sample stream over per-channel histories and registers
// the concealed result. Assumes channel 0 is the first sample after reset.
module conceal_interp
    import conceal_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                c1_flag,
    input  logic                c2_fail,
    input  logic                c2_corrected,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_flag,
    output logic [CH_W-1:0]     out_chan
);
    logic [CH_W-1:0] cur_ch;
    logic            in_bad;
    tagged_t         in_rec;
    logic [NUM_CH-1:0] emit_v;
    tagged_t         rec_v [NUM_CH];
    logic            sel_emit;
    tagged_t         sel_rec;

    conceal_flag u_flag (
        .c1_flag      (c1_flag),
        .c2_fail      (c2_fail),
        .c2_corrected (c2_corrected),
        .bad          (in_bad)
    );

    // Bundle the incoming sample with its flag.
    always_comb begin
        in_rec.data = in_data;
        in_rec.bad  = in_bad;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        conceal_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid && (cur_ch == CH_W'(g))),
            .din   (in_rec),
            .emit  (emit_v[g]),
            .dout  (rec_v[g])
        );
    end

    // Pick the result of the channel that received the current sample.
    always_comb begin
        sel_emit = 1'b0;
        sel_rec  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cur_ch == CH_W'(i)) begin
                sel_emit = emit_v[i];
                sel_rec  = rec_v[i];
            end
        end
    end

    // Advance the channel pointer, wrapping after the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_ch <= '0;
        else if (in_valid)
            cur_ch <= (cur_ch == CH_W'(NUM_CH-1)) ? '0 : cur_ch + 1'b1;
    end

    // Register the output sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_flag  <= 1'b0;
            out_chan  <= '0;
        end else begin
            out_valid <= sel_emit;
            if (sel_emit) begin
                out_data <= sel_rec.data;
                out_flag <= sel_rec.bad;
                out_chan <= cur_ch;
            end
        end
    end

    // R7
    out_follows_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R6
    chan_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_ch == CH_W'(NUM_CH-1)) |=> (cur_ch == '0));
endmodule

// File: tb/conceal_interp_test.sv
module conceal_interp_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        c1_flag = 1'b0, c2_fail = 1'b0, c2_corrected = 1'b0;
    logic        out_valid, out_flag;
    logic [15:0] out_data;
    logic [0:0]  out_chan;
    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    conceal_interp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .c1_flag(c1_flag), .c2_fail(c2_fail), .c2_corrected(c2_corrected),
        .out_valid(out_valid), .out_data(out_data), .out_flag(out_flag),
        .out_chan(out_chan)
    );

    // {data, c1, fail, corr, exp_valid, exp_data, exp_flag, exp_chan}
    localparam logic [37:0] VEC [20] = '{
        {16'(100),    3'b000, 1'b0, 16'(0),      2'b00},
        {16'(-200),   3'b000, 1'b0, 16'(0),      2'b00},
        {16'(300),    3'b000, 1'b1, 16'(100),    2'b00},
        {16'(9999),   3'b010, 1'b1, 16'(-200),   2'b01},
        {16'(7),      3'b101, 1'b1, 16'(300),    2'b00},
        {16'(-100),   3'b000, 1'b1, 16'(-150),   2'b11},
        {16'(500),    3'b000, 1'b1, 16'(400),    2'b10},
        {16'(50),     3'b100, 1'b1, 16'(-100),   2'b01},
        {16'(1),      3'b010, 1'b1, 16'(500),    2'b00},
        {16'(51),     3'b001, 1'b1, 16'(50),     2'b01},
        {16'(2),      3'b010, 1'b1, 16'(500),    2'b10},
        {16'(-3),     3'b000, 1'b1, 16'(51),     2'b01},
        {16'(600),    3'b000, 1'b1, 16'(500),    2'b10},
        {16'(0),      3'b110, 1'b1, 16'(-3),     2'b01},
        {16'(700),    3'b000, 1'b1, 16'(600),    2'b00},
        {16'(-4),     3'b000, 1'b1, 16'(-4),     2'b11},
        {16'(3),      3'b010, 1'b1, 16'(700),    2'b00},
        {16'(32767),  3'b000, 1'b1, 16'(-4),     2'b01},
        {16'(-32768), 3'b000, 1'b1, 16'(-16034), 2'b10},
        {16'(32767),  3'b000, 1'b1, 16'(32767),  2'b01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] d, input logic [2:0] st);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        {c1_flag, c2_fail, c2_corrected} = st;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R8 reset state
        chk("R8 out_valid", 32'(out_valid), 0);
        chk("R8 out_data", 32'(out_data), 0);
        chk("R8 out_flag", 32'(out_flag), 0);

        // Vector stream covering R1, R2, R3, R4, R6, R7
        for (int i = 0; i < 20; i++) begin
            send(VEC[i][37:22], VEC[i][21:19]);
            chk($sformatf("R7 valid v%0d", i), 32'(out_valid), 32'(VEC[i][18]));
            if (VEC[i][18]) begin
                chk($sformatf("R2/R3/R4 data v%0d", i), 32'(out_data), 32'(VEC[i][17:2]));
                chk($sformatf("R1 flag v%0d", i), 32'(out_flag), 32'(VEC[i][1]));
                chk($sformatf("R6 chan v%0d", i), 32'(out_chan), 32'(VEC[i][0]));
            end
            @(negedge clk);
            chk($sformatf("R7 pulse v%0d", i), 32'(out_valid), 0);
        end

        // R8: reset mid-stream clears history; R5: flagged first sample gives zero
        do_reset();
        chk("R8 out_valid after reset", 32'(out_valid), 0);
        send(16'(5), 3'b010);
        chk("R7 no first output", 32'(out_valid), 0);
        send(16'(10), 3'b000);
        send(16'(20), 3'b000);
        chk("R5 valid", 32'(out_valid), 1);
        chk("R5 zero", 32'(out_data), 0);
        chk("R5 flag", 32'(out_flag), 1);
        chk("R6 left first", 32'(out_chan), 0);
        send(16'(30), 3'b000);
        chk("R6 right data", 32'(out_data), 10);
        chk("R6 right chan", 32'(out_chan), 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule